// File: doc/BRIEF.md
# Spike-timing synaptic weight update engine

The engine holds a weight array with one column per output neuron and one row per input channel, and trains it with a two-way timing rule. Every input channel keeps the tick count of its latest spike. Input spikes only refresh these timestamps. When an output neuron fires, the engine walks the weight column of that neuron, one synapse per clock. Each synapse whose input fired recently enough is strengthened. Every other synapse in the column is weakened.

Step sizes are not fixed. A potentiation step gets smaller as the weight approaches full scale, and a depression step gets smaller as the weight approaches the floor. Both follow a decaying exponential of the distance to the bound, read from a 64-entry table that is computed at elaboration. Output firings that arrive while a column walk is running wait in a short queue. A read port returns any stored weight combinationally. Neuron integration and inhibition sit outside the block.

Top module: `stdp_update_engine`

## Requirements
- R1: After reset every weight reads 32768, busy_o is 0 and ovf_o is 0.
- R2: An input spike only records the current tick count for that input and marks it valid; no weight changes.
- R3: For a processed firing, a synapse is potentiated when its input is valid and age = (t_fire - t_input) mod 65536 is below window_i. The new weight is min(65535, w + P[k]), where k = (w - 7) >> 10, P[k] = (655 * E[k]) >> 16, E[0] = 65536 and E[k] = (E[k-1] * 62534) >> 16.
- R4: Every other synapse in the firing column is depressed: the new weight is max(7, w - D[k]), where k = (65535 - w) >> 10 and D[k] = (328 * E[k]) >> 16.
- R5: A firing changes only the column of the output selected by out_sel_i.
- R6: A firing strobed at clock edge c raises busy_o after edge c+1. busy_o stays high for exactly N_IN cycles, and synapse j is written at edge c+2+j.
- R7: Firings that arrive while a walk is running are queued, up to 4 pending, and processed in arrival order.
- R8: A firing that arrives when 4 are pending and none leaves the queue that cycle is dropped, and ovf_o goes to 1 and stays there until reset.
- R9: An input that has never spiked since reset is depressed whatever the window.
- R10: The window bound is exclusive: age equal to window_i depresses, and age equal to window_i - 1 potentiates.
- R11: Weights saturate and never wrap: repeated potentiation settles at 65535 and repeated depression at 7.
- R12: rd_data_o is the weight of output rd_out_i, input rd_in_i, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Advances the time counter by one |
| in_spike_i | input | N_IN | Input spike strobes, one bit per channel |
| out_fire_i | input | 1 | Output firing strobe |
| out_sel_i | input | clog2(N_OUT) | Index of the output that fired |
| window_i | input | TS_W | Potentiation window in ticks |
| rd_out_i | input | clog2(N_OUT) | Read port output index |
| rd_in_i | input | clog2(N_IN) | Read port input index |
| rd_data_o | output | W_W | Selected weight |
| busy_o | output | 1 | Column walk in progress |
| ovf_o | output | 1 | Sticky firing-queue overflow |

## Verification
A firing strobed before edge c passes through the queue register, so busy_o is 0 at the falling edge after c and 1 at the falling edge after c+1. busy_o is then counted for exactly N_IN falling edges. The final synapse lands at the edge where busy_o drops. At that moment the scoreboard monitor reads the expected column through the combinational read port, finishing within 16 ns, before the next queued walk can write at the second edge after. Input spikes and ticks take effect at the following edge, so the bench's time and timestamp model advances only once that edge has passed.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  typedef enum logic {S_IDLE, S_BUSY} walk_st_e;

  // step = (alpha * e^(-k * ln(65536/decay))) in Q16, built by repeated multiply
  function automatic int unsigned exp_step(int unsigned alpha, int unsigned decay,
                                           int unsigned k, int unsigned n);
    longint unsigned e;
    longint unsigned r;
    e = 64'd65536;
    for (int unsigned i = 0; i < n; i++) begin
      if (i < k) e = (e * longint'(decay)) >> 16;
    end
    r = (longint'(alpha) * e) >> 16;
    return int'(r);
  endfunction

endpackage

// File: rtl/stdp_stamp_bank.sv
module stdp_stamp_bank #(
  parameter int N_IN = 16,
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_IN-1:0] spike_i,
  output logic [TS_W-1:0] now_o,
  output logic [TS_W-1:0] stamp_o [N_IN],
  output logic [N_IN-1:0] valid_o
);

  logic [TS_W-1:0] now_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else if (tick_i) now_q <= now_q + 1'b1;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stamp_o[g] <= '0;
        valid_o[g] <= 1'b0;
      end else if (spike_i[g]) begin
        stamp_o[g] <= now_q;
        valid_o[g] <= 1'b1;
      end
    end
  end

  assign now_o = now_q;

  // R2
  spike_marks_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|spike_i) |=> (|valid_o));
  // R9
  valid_never_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_o & $past(valid_o)) == $past(valid_o)));

endmodule

// File: rtl/stdp_evt_fifo.sv
module stdp_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          ovf_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, accept;

  function automatic logic [PW-1:0] ptr_nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign accept  = push_i && (!full || pop_i);
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (accept) wr_q <= ptr_nxt(wr_q);
      if (pop_i)  rd_q <= ptr_nxt(rd_q);
      cnt_q <= cnt_q + CW'(accept) - CW'(pop_i);
      if (push_i && !accept) ovf_o <= 1'b1;
    end
  end

  // R7
  push_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !pop_i) |=> !empty_o);
  // R7
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/stdp_step_unit.sv
module stdp_step_unit #(
  parameter int W_W     = 16,
  parameter int LUT_AW  = 6,
  parameter int W_MIN   = 7,
  parameter int W_MAX   = 65535,
  parameter int ALPHA_P = 655,
  parameter int ALPHA_D = 328,
  parameter int DECAY   = 62534,
  parameter bit EXP_LAW = 1'b1
) (
  input  logic [W_W-1:0] w_i,
  input  logic           pot_i,
  output logic [W_W-1:0] w_o
);
  import stdp_pkg::*;

  localparam int LUT_N = 1 << LUT_AW;
  localparam logic [W_W-1:0] WMIN_V = W_W'(W_MIN);
  localparam logic [W_W-1:0] WMAX_V = W_W'(W_MAX);

  logic [W_W-1:0] step_p, step_d, w_p, w_d;
  logic [W_W:0]   sum_p, floor_d;

  if (EXP_LAW) begin : g_exp
    logic [W_W-1:0] tbl_p [LUT_N];
    logic [W_W-1:0] tbl_d [LUT_N];
    logic [W_W-1:0] dist_p, dist_d;
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
      assign tbl_p[g] = W_W'(exp_step(ALPHA_P, DECAY, g, LUT_N));
      assign tbl_d[g] = W_W'(exp_step(ALPHA_D, DECAY, g, LUT_N));
    end
    // index by top bits of the distance to the bound being approached
    assign dist_p = w_i - WMIN_V;
    assign dist_d = WMAX_V - w_i;
    assign step_p = tbl_p[dist_p[W_W-1 -: LUT_AW]];
    assign step_d = tbl_d[dist_d[W_W-1 -: LUT_AW]];
  end else begin : g_flat
    assign step_p = W_W'(ALPHA_P);
    assign step_d = W_W'(ALPHA_D);
  end

  assign sum_p   = {1'b0, w_i} + {1'b0, step_p};
  assign floor_d = {1'b0, WMIN_V} + {1'b0, step_d};
  assign w_p     = (sum_p > {1'b0, WMAX_V}) ? WMAX_V : sum_p[W_W-1:0];
  assign w_d     = ({1'b0, w_i} < floor_d) ? WMIN_V : (w_i - step_d);
  assign w_o     = pot_i ? w_p : w_d;

endmodule

// File: rtl/stdp_update_engine.sv
module stdp_update_engine #(
  parameter int N_IN       = 16,
  parameter int N_OUT      = 4,
  parameter int W_W        = 16,
  parameter int TS_W       = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int LUT_AW     = 6,
  parameter int W_MIN      = 7,
  parameter int W_MAX      = 65535,
  parameter int W_INIT     = 32768,
  parameter int ALPHA_P    = 655,
  parameter int ALPHA_D    = 328,
  parameter int DECAY      = 62534,
  localparam int OI_W      = $clog2(N_OUT),
  localparam int II_W      = $clog2(N_IN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_IN-1:0] in_spike_i,
  input  logic            out_fire_i,
  input  logic [OI_W-1:0] out_sel_i,
  input  logic [TS_W-1:0] window_i,
  input  logic [OI_W-1:0] rd_out_i,
  input  logic [II_W-1:0] rd_in_i,
  output logic [W_W-1:0]  rd_data_o,
  output logic            busy_o,
  output logic            ovf_o
);
  import stdp_pkg::*;

  localparam int EV_W = OI_W + TS_W;

  logic [TS_W-1:0] now;
  logic [TS_W-1:0] stamp [N_IN];
  logic [N_IN-1:0] stamp_vld;
  logic [EV_W-1:0] ev_head;
  logic            ev_empty, ev_pop;

  walk_st_e        st_q;
  logic [OI_W-1:0] cur_o_q;
  logic [TS_W-1:0] cur_t_q;
  logic [II_W-1:0] col_q;
  logic [W_W-1:0]  wgt_q [N_OUT][N_IN];
  logic [W_W-1:0]  cur_w, new_w;
  logic [TS_W-1:0] age;
  logic            in_win, last_col;

  stdp_stamp_bank #(.N_IN(N_IN), .TS_W(TS_W)) u_stamps (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .spike_i(in_spike_i),
    .now_o(now), .stamp_o(stamp), .valid_o(stamp_vld)
  );

  stdp_evt_fifo #(.DEPTH(FIFO_DEPTH), .DW(EV_W)) u_evq (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(out_fire_i), .data_i({out_sel_i, now}),
    .pop_i(ev_pop), .data_o(ev_head), .empty_o(ev_empty), .ovf_o(ovf_o)
  );

  stdp_step_unit #(
    .W_W(W_W), .LUT_AW(LUT_AW), .W_MIN(W_MIN), .W_MAX(W_MAX),
    .ALPHA_P(ALPHA_P), .ALPHA_D(ALPHA_D), .DECAY(DECAY), .EXP_LAW(1'b1)
  ) u_step (
    .w_i(cur_w), .pot_i(in_win), .w_o(new_w)
  );

  assign ev_pop   = (st_q == S_IDLE) && !ev_empty;
  assign last_col = (col_q == II_W'(N_IN - 1));
  assign cur_w    = wgt_q[cur_o_q][col_q];
  // age is modular; a stamp newer than the firing wraps to a large age
  assign age      = cur_t_q - stamp[col_q];
  assign in_win   = stamp_vld[col_q] && (age < window_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cur_o_q <= '0;
      cur_t_q <= '0;
      col_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (ev_pop) begin
          st_q             <= S_BUSY;
          col_q            <= '0;
          {cur_o_q, cur_t_q} <= ev_head;
        end
        S_BUSY: begin
          col_q <= col_q + 1'b1;
          if (last_col) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < N_OUT; o++)
        for (int i = 0; i < N_IN; i++)
          wgt_q[o][i] <= W_W'(W_INIT);
    end else if (st_q == S_BUSY) begin
      wgt_q[cur_o_q][col_q] <= new_w;
    end
  end

  assign busy_o    = (st_q == S_BUSY);
  assign rd_data_o = wgt_q[rd_out_i][rd_in_i];

  // R6
  busy_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!ev_empty));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R11
  floor_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (new_w >= W_W'(W_MIN)));
  // R3
  pot_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && in_win) |-> (new_w >= cur_w));
  // R4
  dep_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !in_win) |-> (new_w <= cur_w));

endmodule

// File: tb/stdp_update_engine_tb.sv
module stdp_update_engine_tb_top;
  localparam int N_IN  = 16;
  localparam int N_OUT = 4;
  localparam int WMIN  = 7;
  localparam int WMAX  = 65535;
  localparam int WINIT = 32768;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick_i = 1'b0;
  logic [N_IN-1:0] in_spike_i = '0;
  logic            out_fire_i = 1'b0;
  logic [1:0]      out_sel_i = '0;
  logic [15:0]     window_i = '0;
  logic [1:0]      rd_out_i = '0;
  logic [3:0]      rd_in_i = '0;
  logic [15:0]     rd_data_o;
  logic            busy_o, ovf_o;

  always #10 clk_i = ~clk_i;

  stdp_update_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .in_spike_i(in_spike_i),
    .out_fire_i(out_fire_i), .out_sel_i(out_sel_i), .window_i(window_i),
    .rd_out_i(rd_out_i), .rd_in_i(rd_in_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .ovf_o(ovf_o)
  );

  typedef struct {int o; int i; int w;} exp_t;

  int   n_chk = 0, n_fail = 0;
  int   model_w [N_OUT][N_IN];
  int   stamp [N_IN];
  bit   sval [N_IN];
  int   now = 0;
  int   win = 0;
  bit   ended = 1'b0;
  exp_t sb_q [$];

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int e_tab(int k);
    longint e = 65536;
    for (int i = 0; i < k; i++) e = (e * 62534) >> 16;
    return int'(e);
  endfunction

  function automatic int upd(int w, bit pot);
    int k, s;
    if (pot) begin
      k = ((w - WMIN) >> 10) & 63;
      s = (655 * e_tab(k)) >> 16;
      return (w + s > WMAX) ? WMAX : w + s;
    end
    k = ((WMAX - w) >> 10) & 63;
    s = (328 * e_tab(k)) >> 16;
    return (w < WMIN + s) ? WMIN : w - s;
  endfunction

  task automatic set_win(int v);
    @(negedge clk_i);
    win = v;
    window_i = 16'(v);
  endtask

  task automatic do_tick(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      now = (now + 1) & 16'hFFFF;
    end
  endtask

  task automatic spike_in(logic [N_IN-1:0] mask);
    @(negedge clk_i); in_spike_i = mask;
    @(negedge clk_i); in_spike_i = '0;
    for (int i = 0; i < N_IN; i++)
      if (mask[i]) begin stamp[i] = now; sval[i] = 1'b1; end
  endtask

  // driver side of the scoreboard: model the column, queue expected weights
  task automatic queue_evt(int o);
    for (int i = 0; i < N_IN; i++) begin
      bit pot;
      pot = sval[i] && (((now - stamp[i]) & 16'hFFFF) < win);
      model_w[o][i] = upd(model_w[o][i], pot);
      sb_q.push_back('{o: o, i: i, w: model_w[o][i]});
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk_i);
      if (busy_o) quiet = 0; else quiet++;
    end
  endtask

  task automatic fire(int o);
    queue_evt(o);
    @(negedge clk_i); out_fire_i = 1'b1; out_sel_i = 2'(o);
    @(negedge clk_i); out_fire_i = 1'b0;
    wait_idle();
  endtask

  task automatic rd(int o, int i, output int v);
    rd_out_i = 2'(o);
    rd_in_i  = 4'(i);
    #1;
    v = int'(rd_data_o);
  endtask

  task automatic compare_all(string req);
    int v;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++) begin
        rd(o, i, v);
        chk(req, v, model_w[o][i]);
      end
  endtask

  // monitor side: each falling busy_o completes one column walk
  initial begin
    wait (rst_ni);
    forever begin
      @(negedge busy_o);
      for (int j = 0; j < N_IN; j++) begin
        exp_t e;
        int   v;
        if (sb_q.size() == 0) begin
          chk("R7 walk without queued expectation", 1, 0);
          break;
        end
        e = sb_q.pop_front();
        rd(e.o, e.i, v);
        chk("R3 R4 column update", v, e.w);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int v, cyc;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++) model_w[o][i] = WINIT;
    for (int i = 0; i < N_IN; i++) begin stamp[i] = 0; sval[i] = 1'b0; end

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state, read through R12 port
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 ovf after reset", int'(ovf_o), 0);
    compare_all("R1 R12 reset weights");

    // R2: input spikes alone leave weights untouched
    set_win(16'hFFFF);
    do_tick(3);
    spike_in(16'h000F);
    repeat (4) @(negedge clk_i);
    chk("R2 busy after input spikes", int'(busy_o), 0);
    compare_all("R2 weights after input spikes");

    // R3 R9 R6: inputs 0-3 in window, 4-15 never spiked
    do_tick(2);
    queue_evt(0);
    @(negedge clk_i); out_fire_i = 1'b1; out_sel_i = 2'd0;
    @(negedge clk_i); out_fire_i = 1'b0;
    chk("R6 busy one edge after strobe", int'(busy_o), 0);
    cyc = 0;
    @(negedge clk_i);
    while (busy_o && cyc < 100) begin cyc++; @(negedge clk_i); end
    chk("R6 busy length", cyc, N_IN);
    wait_idle();
    rd(0, 0, v); chk("R3 potentiated input 0", int'(v > WINIT), 1);
    rd(0, 9, v); chk("R9 never-spiked input depressed", int'(v < WINIT), 1);
    compare_all("R5 only fired column changes");

    // R10 window edge; R4 stale inputs 0-3
    set_win(4);
    do_tick(1);
    spike_in(16'h0010);
    do_tick(1);
    spike_in(16'h0020);
    do_tick(3);
    fire(1);
    rd(1, 4, v); chk("R10 age equal to window depresses", int'(v < WINIT), 1);
    rd(1, 5, v); chk("R10 age one below window potentiates", int'(v > WINIT), 1);
    rd(1, 0, v); chk("R4 stale input depressed", int'(v < WINIT), 1);
    compare_all("R5 after second firing");

    // R7 R8 queueing and overflow
    set_win(0);
    begin
      int seq [5] = '{0, 1, 2, 3, 0};
      for (int k = 0; k < 5; k++) begin
        queue_evt(seq[k]);
        @(negedge clk_i); out_fire_i = 1'b1; out_sel_i = 2'(seq[k]);
      end
    end
    @(negedge clk_i);
    chk("R8 no overflow with four pending", int'(ovf_o), 0);
    out_fire_i = 1'b1; out_sel_i = 2'd2;
    @(negedge clk_i); out_fire_i = 1'b0;
    chk("R8 overflow flag on fifth pending", int'(ovf_o), 1);
    wait_idle();
    chk("R7 all queued walks consumed", sb_q.size(), 0);
    compare_all("R8 dropped firing has no effect");

    // R11 saturation at both bounds
    set_win(16'hFFFF);
    spike_in('1);
    for (int k = 0; k < 900; k++) fire(1);
    for (int i = 0; i < N_IN; i++) begin rd(1, i, v); chk("R11 upper saturation", v, WMAX); end
    set_win(0);
    for (int k = 0; k < 2000; k++) fire(2);
    for (int i = 0; i < N_IN; i++) begin rd(2, i, v); chk("R11 lower saturation", v, WMIN); end
    compare_all("R5 after saturation runs");
    chk("R8 overflow flag still set", int'(ovf_o), 1);
    chk("R7 scoreboard drained", sb_q.size(), 0);

    finish_run();
  end

endmodule